// File: doc/BRIEF.md
# Key-Protected Fault Injection Controller

This block holds four protected configuration registers: mode, configuration, interrupt mask and write-protect mode. When software writes one of them, the block stores one even-parity bit for each byte group. Every cycle a checker recomputes the parity of the stored value and compares it with the stored parity bits. A mismatch sets a sticky status field that software reads from the write-protect status register. It also raises a fault output.

To prove that the checker works, software can write to a fault-injection register. A write counts only if it carries a 24-bit key. An accepted write with the single-fault enable set flips the stored parity bit of byte 0 in each selected register. The configuration value itself does not change. The fault stays until software rewrites the register, because that write recomputes the parity. A separate command locks the fault-injection register until the next hardware reset, which protects the check path once it has been tested.

All accesses use a one-cycle write strobe or read strobe on a small address/data port. Read data is combinational from the address. Reading the status register clears it at the next clock edge.

Top module: `fault_guard_regs`

## Requirements
- R1: After reset, every register reads 0 and `fault_o` is 0.
- R2: The mode, configuration, interrupt-mask and write-protect-mode registers sit at 0x00, 0x04, 0x08 and 0x0C. Each is written by a write strobe and read back unchanged. After clean writes no fault is reported. Unmapped addresses read 0.
- R3: A write to the fault-injection register at 0x38 is accepted only when bits 31:8 equal 0x504649. Any other key discards the whole write. Bits 31:8 always read 0.
- R4: An accepted write with bit 5 (single-fault enable) set injects a fault into each register selected by bits 3:0. Bit 0 selects mode, bit 1 configuration, bit 2 interrupt mask and bit 3 write-protect mode. With bit 5 clear, nothing is injected.
- R5: An injected fault leaves the stored value of the target register unchanged.
- R6: One cycle after a parity mismatch, the status register at 0x10 reads 3 in bits 1:0. Bits 11:8 flag which registers mismatched, in the same order as the selection bits. Bits 1:0 only ever read 0 or 3.
- R7: Status flags are sticky. A status read returns the flags and clears them at the next edge. A mismatch that still exists sets its flag again in that same cycle. Rewriting a faulted register removes the mismatch. `fault_o` is 1 exactly while any flag is set.
- R8: An accepted write with bit 7 set, bits 5 and 3:0 clear, and the status error field at 0 locks the register. Bit 7 then reads 1, and every later write to 0x38 is ignored until hardware reset.
- R9: A lock request is ignored when the status error field is non-zero or when bit 5 or any of bits 3:0 is set in the same write. The rest of that write still applies.
- R10: The fault-injection register reads back bits 5 and 3:0 of the last accepted write, and bit 7 as the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe (clears status when addressed) |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data |
| fault_o | output | 1 | High while any status flag is set |

## Verification
The injection path is tried with four kinds of pattern:
- A wrong key that differs only in its lowest bit, which shows that the full key comparison works.
- A correct key with the enable clear, which separates key acceptance from injection.
- A single-target injection, which shows each selection bit maps to the right flag.
- A three-target injection, which shows that selections combine.

The lock command is tried three ways: while a fault is pending, together with other bits set, and cleanly. Afterwards a hardware reset proves that the lock lasts only until reset. Repeated status reads with the fault still present, and then after a repair, tell the sticky-clear behaviour apart from the re-detection of a persisting mismatch.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
   localparam int NPROT      = 4;
   localparam int PROT_BASE  = 'h00;
   localparam int PROT_STEP  = 4;
   localparam int STAT_ADDR  = 'h10;
   localparam int FIR_ADDR   = 'h38;
   localparam int KEY_LSB    = 8;
   localparam int KEY_W      = 24;
   localparam int LOCK_BIT   = 7;
   localparam int SFEN_BIT   = 5;
   localparam int FLAG_LSB   = 8;
   localparam logic [1:0] ERR_FAULT = 2'd3;
   typedef enum logic [1:0] {
      IDX_MODE = 2'd0,
      IDX_CFG  = 2'd1,
      IDX_IMSK = 2'd2,
      IDX_WPM  = 2'd3
   } prot_idx_e;
endpackage

// File: rtl/prot_reg.sv
module prot_reg #(
   parameter int DATA_W = 32,
   parameter int GRP_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              inj_i,
   output logic [DATA_W-1:0] data_o,
   output logic              mismatch_o
);
   localparam int NGRP = DATA_W / GRP_W;

   if (DATA_W % GRP_W != 0) begin : g_bad_grp
      $error("prot_reg: DATA_W must be a multiple of GRP_W");
   end

   logic [DATA_W-1:0] data_q;
   logic [NGRP-1:0]   par_q;
   logic [NGRP-1:0]   par_wr;
   logic [NGRP-1:0]   par_chk;

   if (NGRP == 1) begin : g_word_par
      assign par_wr[0]  = ^wdata_i;
      assign par_chk[0] = ^data_q;
   end else begin : g_grp_par
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign par_wr[g]  = ^wdata_i[g*GRP_W +: GRP_W];
         assign par_chk[g] = ^data_q[g*GRP_W +: GRP_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         par_q  <= '0;
      end else if (wr_i) begin
         data_q <= wdata_i;
         par_q  <= par_wr;
      end else if (inj_i) begin
         par_q[0] <= ~par_q[0];
      end
   end

   assign data_o     = data_q;
   assign mismatch_o = |(par_q ^ par_chk);
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
   import fault_guard_pkg::*;
#(
   parameter int           DATA_W  = 32,
   parameter logic [23:0]  KEY_VAL = 24'h504649
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              err_zero_i,
   output logic [NPROT-1:0]  inj_o,
   output logic              lock_o,
   output logic [DATA_W-1:0] view_o
);
   if (KEY_LSB + KEY_W > DATA_W) begin : g_bad_key
      $error("fir_ctrl: key field does not fit in DATA_W");
   end
   if (NPROT > SFEN_BIT) begin : g_bad_sel
      $error("fir_ctrl: selection field overlaps enable bit");
   end

   logic             lock_q;
   logic             sfen_q;
   logic [NPROT-1:0] sel_q;
   logic             key_ok;
   logic             accept;
   logic             lock_req;
   logic             unused_wbits;

   assign key_ok   = (wdata_i[KEY_LSB +: KEY_W] == KEY_VAL);
   assign accept   = wr_i && !lock_q && key_ok;
   assign lock_req = wdata_i[LOCK_BIT] && !wdata_i[SFEN_BIT]
                     && (wdata_i[NPROT-1:0] == '0) && err_zero_i;
   assign unused_wbits = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         sfen_q <= 1'b0;
         sel_q  <= '0;
      end else if (accept) begin
         sfen_q <= wdata_i[SFEN_BIT];
         sel_q  <= wdata_i[NPROT-1:0];
         if (lock_req) lock_q <= 1'b1;
      end
   end

   assign inj_o  = (accept && wdata_i[SFEN_BIT]) ? wdata_i[NPROT-1:0] : '0;
   assign lock_o = lock_q;

   always_comb begin
      view_o             = '0;
      view_o[LOCK_BIT]   = lock_q;
      view_o[SFEN_BIT]   = sfen_q;
      view_o[NPROT-1:0]  = sel_q;
   end
endmodule

// File: rtl/err_status.sv
module err_status
   import fault_guard_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPROT-1:0] mismatch_i,
   input  logic             rd_clr_i,
   output logic [1:0]       code_o,
   output logic [NPROT-1:0] flags_o
);
   logic [NPROT-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (rd_clr_i ? '0 : flags_q) | mismatch_i;
   end

   assign flags_o = flags_q;
   assign code_o  = (|flags_q) ? ERR_FAULT : 2'd0;
endmodule

// File: rtl/fault_guard_regs.sv
module fault_guard_regs
   import fault_guard_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          ADDR_W  = 8,
   parameter int          GRP_W   = 8,
   parameter logic [23:0] KEY_VAL = 24'h504649
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              fault_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_FIR  = ADDR_W'(FIR_ADDR);

   if (DATA_W < FLAG_LSB + NPROT || DATA_W < KEY_LSB + KEY_W) begin : g_bad_w
      $error("fault_guard_regs: DATA_W too narrow");
   end
   if (ADDR_W < 6) begin : g_bad_a
      $error("fault_guard_regs: ADDR_W too narrow for map");
   end

   logic [NPROT-1:0]             inj;
   logic [NPROT-1:0]             mismatch;
   logic [NPROT-1:0][DATA_W-1:0] prot_data;
   logic [NPROT-1:0]             st_flags;
   logic [1:0]                   st_code;
   logic                         lock;
   logic [DATA_W-1:0]            fir_view;
   logic                         fir_wr;
   logic                         stat_rd;

   assign fir_wr  = wr_en && (addr == A_FIR);
   assign stat_rd = rd_en && (addr == A_STAT);

   for (genvar i = 0; i < NPROT; i++) begin : g_prot
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PROT_BASE + PROT_STEP * i);
      prot_reg #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_reg (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_i      (wr_en && (addr == MY_ADDR)),
         .wdata_i   (wdata),
         .inj_i     (inj[i]),
         .data_o    (prot_data[i]),
         .mismatch_o(mismatch[i])
      );
   end

   fir_ctrl #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_fir (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (fir_wr),
      .wdata_i   (wdata),
      .err_zero_i(st_code == 2'd0),
      .inj_o     (inj),
      .lock_o    (lock),
      .view_o    (fir_view)
   );

   err_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .mismatch_i(mismatch),
      .rd_clr_i  (stat_rd),
      .code_o    (st_code),
      .flags_o   (st_flags)
   );

   always_comb begin
      rdata = '0;
      if (addr == A_FIR) begin
         rdata = fir_view;
      end else if (addr == A_STAT) begin
         rdata[1:0]                = st_code;
         rdata[FLAG_LSB +: NPROT]  = st_flags;
      end else begin
         for (int i = 0; i < NPROT; i++) begin
            if (addr == ADDR_W'(PROT_BASE + PROT_STEP * i)) rdata = prot_data[i];
         end
      end
   end

   assign fault_o = |st_flags;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk
   import fault_guard_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          ADDR_W  = 8,
   parameter logic [23:0] KEY_VAL = 24'h504649
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             wr_en,
   input logic                             rd_en,
   input logic [ADDR_W-1:0]                addr,
   input logic [DATA_W-1:0]                wdata,
   input logic [DATA_W-1:0]                rdata,
   input logic                             fault_o,
   input logic                             lock,
   input logic [DATA_W-1:0]                fir_view,
   input logic [NPROT-1:0]                 mismatch,
   input logic [NPROT-1:0]                 st_flags,
   input logic [NPROT-1:0][DATA_W-1:0]     prot_data
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_FIR  = ADDR_W'(FIR_ADDR);

   // R8
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   // R8
   locked_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(fir_view));

   // R3
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_FIR && wdata[KEY_LSB +: KEY_W] != KEY_VAL) |=> $stable(fir_view));

   // R6
   code_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_STAT) |-> (rdata[1:0] == 2'd0 || rdata[1:0] == 2'd3));

   // R7
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !(rd_en && addr == A_STAT)) |=> fault_o);

   for (genvar i = 0; i < NPROT; i++) begin : g_reg_chk
      // R5
      data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && addr == ADDR_W'(PROT_BASE + PROT_STEP * i)) |=> $stable(prot_data[i]));
      // R6
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mismatch[i] |=> st_flags[i]);
   end
endmodule

bind fault_guard_regs fault_guard_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .fault_o  (fault_o),
   .lock     (lock),
   .fir_view (fir_view),
   .mismatch (mismatch),
   .st_flags (st_flags),
   .prot_data(prot_data)
);

// File: tb/fault_guard_regs_tb.sv
`timescale 1ns/1ps
module fault_guard_regs_tb;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam logic [31:0] KEY  = 32'h5046_4900;
   localparam logic [31:0] BADK = 32'h5046_4800;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              fault_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [DATA_W-1:0] exp;
      logic [ADDR_W-1:0] a;
      string             tag;
   } rd_item_t;
   rd_item_t exp_q[$];

   always #2 clk = ~clk;

   fault_guard_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .fault_o(fault_o)
   );

   task automatic check(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      if (rd_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard-empty", rdata, '0);
         end else begin
            rd_item_t it;
            it = exp_q.pop_front();
            check(rdata === it.exp, it.tag, rdata, it.exp);
         end
      end
   end

   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                         input string tag);
      rd_item_t it;
      it.exp = e; it.a = a; it.tag = tag;
      exp_q.push_back(it);
      rd_en = 1'b1; addr = a;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", '0, '0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      check(fault_o === 1'b0, "R1 fault_o after reset", {31'b0, fault_o}, '0);
      bus_rd(8'h00, '0, "R1 mode reset");
      bus_rd(8'h0C, '0, "R1 wpm reset");
      bus_rd(8'h10, '0, "R1 status reset");
      bus_rd(8'h38, '0, "R1 fir reset");

      // R2 plain register access
      bus_wr(8'h00, 32'h1234_5678);
      bus_wr(8'h04, 32'hA5A5_0001);
      bus_wr(8'h08, 32'hFFFF_FFFF);
      bus_wr(8'h0C, 32'h0000_00FF);
      bus_rd(8'h00, 32'h1234_5678, "R2 mode readback");
      bus_rd(8'h04, 32'hA5A5_0001, "R2 cfg readback");
      bus_rd(8'h08, 32'hFFFF_FFFF, "R2 imsk readback");
      bus_rd(8'h0C, 32'h0000_00FF, "R2 wpm readback");
      bus_rd(8'h10, '0, "R2 no fault after clean writes");
      bus_rd(8'h20, '0, "R2 unmapped reads zero");

      // R3 wrong key discards everything
      bus_wr(8'h38, BADK | 32'h2F);
      idle(1);
      bus_rd(8'h38, '0, "R3 bad key discarded");
      bus_rd(8'h10, '0, "R3 bad key no injection");

      // R4 enable clear: accepted but no injection (R10 readback)
      bus_wr(8'h38, KEY | 32'h01);
      idle(1);
      bus_rd(8'h38, 32'h01, "R10 fir readback, key reads zero");
      bus_rd(8'h10, '0, "R4 no injection without enable");

      // R4 single injection into configuration
      bus_wr(8'h38, KEY | 32'h22);
      idle(1);
      check(fault_o === 1'b1, "R7 fault_o raised", {31'b0, fault_o}, 32'h1);
      bus_rd(8'h10, 32'h0000_0203, "R6 cfg fault status");
      bus_rd(8'h04, 32'hA5A5_0001, "R5 cfg value unchanged");
      bus_rd(8'h38, 32'h22, "R3 key field reads zero");
      bus_rd(8'h10, 32'h0000_0203, "R7 persisting fault re-detected");
      bus_wr(8'h04, 32'hA5A5_0001);
      bus_rd(8'h10, 32'h0000_0203, "R7 sticky after repair");
      bus_rd(8'h10, '0, "R7 cleared by read");
      check(fault_o === 1'b0, "R7 fault_o cleared", {31'b0, fault_o}, '0);

      // R4 multiple selection: mode, imsk, wpm
      bus_wr(8'h38, KEY | 32'h2D);
      idle(1);
      check(fault_o === 1'b1, "R4 multi fault_o", {31'b0, fault_o}, 32'h1);
      // R9 lock refused while error pending
      bus_wr(8'h38, KEY | 32'h80);
      bus_rd(8'h38, 32'h00, "R9 lock refused with error pending");
      bus_wr(8'h00, 32'h1234_5678);
      bus_wr(8'h08, 32'hFFFF_FFFF);
      bus_wr(8'h0C, 32'h0000_00FF);
      bus_rd(8'h10, 32'h0000_0D03, "R4 three targets flagged");
      bus_rd(8'h10, '0, "R7 cleared after repair");
      bus_rd(8'h00, 32'h1234_5678, "R5 mode value intact");

      // R9 lock refused when other bits set
      bus_wr(8'h38, KEY | 32'hA0);
      bus_rd(8'h38, 32'h20, "R9 lock refused with enable set");
      bus_rd(8'h10, '0, "R4 enable without targets injects nothing");

      // R8 clean lock
      bus_wr(8'h38, KEY | 32'h80);
      bus_rd(8'h38, 32'h80, "R8 lock bit reads one");
      bus_wr(8'h38, KEY | 32'h21);
      idle(1);
      bus_rd(8'h38, 32'h80, "R8 locked register ignores write");
      bus_rd(8'h10, '0, "R8 no injection while locked");
      check(fault_o === 1'b0, "R8 fault_o low while locked", {31'b0, fault_o}, '0);

      // R8 lock released only by reset
      do_reset();
      bus_rd(8'h38, '0, "R8 lock cleared by reset");
      bus_wr(8'h38, KEY | 32'h21);
      idle(1);
      bus_rd(8'h10, 32'h0000_0103, "R8 injection works after reset");

      idle(2);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule